// File: doc/BRIEF.md
# Chunk-Redundant Cache Line Remapper

This block sits between a cache data array and the processor. At low supply voltage some SRAM cells fail. The block hides those failures by treating a group of physical lines as one redundancy unit. One line in each group is a spare line and is not handed out as data. Every other line in the group borrows healthy chunks from that spare at the positions where its own chunks are faulty. Groups are formed so that no two lines share a faulty chunk position, so one spare line can serve several data lines at once.

The block holds three per-line tables, loaded through a configuration port:

- a fault mask with one bit per chunk;
- a pointer to the group's spare line;
- a flag that marks the line itself as a spare.

A read returns the patched line one cycle after the request. A write splits the incoming line between the data line and its spare. When `low_pwr` is low, the remapping is switched off: every line, including former spares, is an ordinary line. The data array and the tables are modelled as register arrays.

Top module: `cache_chunk_remap`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_valid`, `err` and `rd_data` are 0. Every line of the data array and every table entry is cleared, so a read of any line returns 0.
- R2: A read request (`req_valid`=1, `req_we`=0) gives `rd_valid`=1 in the next cycle only. A write request, or no request, gives `rd_valid`=0 in the next cycle.
- R3: In a low-power read, output chunk i is `rd_data[i*CHUNK_W +: CHUNK_W]`. It comes from the spare line named by the pointer of the requested line when fault bit i of that line is 1. Otherwise it comes from the requested line.
- R4: In a low-power write, chunks whose fault bit is 0 are written into the data line. Chunks whose fault bit is 1 are written into the same chunk positions of the spare line. The faulty chunks of the data line are not changed, and neither are the other chunks of the spare line.
- R5: In high-power mode (`low_pwr`=0), reads and writes move the whole line directly, and the fault masks, spare pointers and spare flags have no effect. Spare lines are readable and writable, and `err` stays 0.
- R6: In low-power mode, a request to a line whose spare flag is 1 sets `err`=1 in the next cycle. For a read, `rd_data` is 0. A write to such a line changes no line of the array.
- R7: A configuration write takes effect from the next cycle. A request in the same cycle as a configuration write to its own line uses the table entry that was there before.
- R8: In low-power mode, a line with an all-zero fault mask reads and writes exactly like a plain line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_pwr | input | 1 | 1 enables chunk remapping; 0 bypasses it |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_line | input | IDX_W | Line index of the access |
| req_wdata | input | LINE_W | Write data |
| cfg_we | input | 1 | Load the table entry of `cfg_line` |
| cfg_line | input | IDX_W | Line whose table entry is loaded |
| cfg_fault | input | CHUNKS | Fault mask, bit i for chunk i |
| cfg_spare | input | IDX_W | Spare-line pointer |
| cfg_sac | input | 1 | Spare flag of the line |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | LINE_W | Patched read data |
| err | output | 1 | Access to a spare line in low-power mode |

## Verification
A request and a configuration write to the same line's table entry can land in the same cycle. The bench provokes this by issuing a low-power read of a patched line while it clears that line's fault mask. The read must still return the patched value built from the old mask. The next read must return the raw data-line contents, which shows the new mask was in force one cycle later. A low-power write also updates two lines in one cycle. This is judged by reading both lines back in high-power mode and comparing each against the expected split.

// File: rtl/cache_chunk_remap.sv
module cache_chunk_remap #(
  parameter int LINES   = 16,
  parameter int CHUNK_W = 4,
  parameter int CHUNKS  = 8,
  localparam int LINE_W = CHUNK_W * CHUNKS,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_pwr,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [IDX_W-1:0]  req_line,
  input  logic [LINE_W-1:0] req_wdata,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_line,
  input  logic [CHUNKS-1:0] cfg_fault,
  input  logic [IDX_W-1:0]  cfg_spare,
  input  logic              cfg_sac,
  output logic              rd_valid,
  output logic [LINE_W-1:0] rd_data,
  output logic              err
);

  logic [LINE_W-1:0] mem  [LINES];
  logic [CHUNKS-1:0] fmap [LINES];
  logic [IDX_W-1:0]  smap [LINES];
  logic [LINES-1:0]  sac;

  logic [IDX_W-1:0]  spare_idx;
  logic [CHUNKS-1:0] fbits;
  logic [LINE_W-1:0] dline, sline, fmask;

  assign spare_idx = smap[req_line];
  assign fbits     = fmap[req_line];
  assign dline     = mem[req_line];
  assign sline     = mem[spare_idx];

  for (genvar g = 0; g < CHUNKS; g++) begin : g_mask
    assign fmask[g*CHUNK_W +: CHUNK_W] = {CHUNK_W{fbits[g]}};
  end

  logic              blocked, rd_req, do_wr, spare_wr;
  logic [LINE_W-1:0] rd_mix, dnew, snew;

  assign blocked  = low_pwr & sac[req_line];
  assign rd_req   = req_valid & ~req_we;
  assign do_wr    = req_valid & req_we & ~blocked;
  assign spare_wr = do_wr & low_pwr & (|fbits) & (spare_idx != req_line);

  assign rd_mix = low_pwr ? ((dline & ~fmask) | (sline & fmask)) : dline;
  assign dnew   = low_pwr ? ((dline & fmask) | (req_wdata & ~fmask)) : req_wdata;
  assign snew   = (sline & ~fmask) | (req_wdata & fmask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (do_wr && req_line == IDX_W'(i))
          mem[i] <= dnew;
        else if (spare_wr && spare_idx == IDX_W'(i))
          mem[i] <= snew;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        fmap[i] <= '0;
        smap[i] <= '0;
      end
      sac <= '0;
    end else if (cfg_we) begin
      fmap[cfg_line] <= cfg_fault;
      smap[cfg_line] <= cfg_spare;
      sac[cfg_line]  <= cfg_sac;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      err      <= req_valid & blocked;
      if (rd_req) rd_data <= blocked ? '0 : rd_mix;
    end
  end

endmodule

// File: rtl/cache_chunk_remap_chk.sv
module cache_chunk_remap_chk #(
  parameter int LINE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              low_pwr,
  input logic              req_valid,
  input logic              req_we,
  input logic              rd_valid,
  input logic [LINE_W-1:0] rd_data,
  input logic              err
);

  // R1
  rst_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!rd_valid && !err));

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rd_valid);

  // R2
  rd_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rd_valid);

  // R5
  hp_noerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !low_pwr) |=> !err);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid && low_pwr));

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err) |-> (rd_data == '0));

endmodule

bind cache_chunk_remap cache_chunk_remap_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .low_pwr(low_pwr), .req_valid(req_valid),
  .req_we(req_we), .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
);

// File: tb/cache_chunk_remap_bench.sv
module cache_chunk_remap_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        low_pwr = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [3:0]  req_line = '0;
  logic [31:0] req_wdata = '0;
  logic        cfg_we = 1'b0, cfg_sac = 1'b0;
  logic [3:0]  cfg_line = '0, cfg_spare = '0;
  logic [7:0]  cfg_fault = '0;
  logic        rd_valid, err;
  logic [31:0] rd_data;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  cache_chunk_remap u_cache_chunk_remap (
    .clk(clk), .rst_n(rst_n), .low_pwr(low_pwr), .req_valid(req_valid),
    .req_we(req_we), .req_line(req_line), .req_wdata(req_wdata),
    .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_fault(cfg_fault),
    .cfg_spare(cfg_spare), .cfg_sac(cfg_sac),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
  );

  typedef struct packed {
    logic        lp;
    logic        we;
    logic [3:0]  line;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        eerr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 4'd4,  32'h11111111, 32'h0,        1'b0, 8'd5}, // R5 plain write
    '{1'b0, 1'b1, 4'd10, 32'hAAAAAAAA, 32'h0,        1'b0, 8'd5}, // R5 write spare
    '{1'b0, 1'b1, 4'd15, 32'h55555555, 32'h0,        1'b0, 8'd5}, // R5
    '{1'b0, 1'b1, 4'd2,  32'h0BADF00D, 32'h0,        1'b0, 8'd5}, // R5
    '{1'b0, 1'b0, 4'd10, 32'h0,        32'hAAAAAAAA, 1'b0, 8'd5}, // R5 spare readable
    '{1'b1, 1'b0, 4'd4,  32'h0,        32'h111111AA, 1'b0, 8'd3}, // R3
    '{1'b1, 1'b0, 4'd15, 32'h0,        32'h55AA5555, 1'b0, 8'd3}, // R3
    '{1'b1, 1'b1, 4'd4,  32'h12345678, 32'h0,        1'b0, 8'd4}, // R4
    '{1'b1, 1'b0, 4'd4,  32'h0,        32'h12345678, 1'b0, 8'd4}, // R4
    '{1'b0, 1'b0, 4'd10, 32'h0,        32'hAAAAAA78, 1'b0, 8'd4}, // R4 spare split
    '{1'b0, 1'b0, 4'd4,  32'h0,        32'h12345611, 1'b0, 8'd4}, // R4 faulty kept
    '{1'b1, 1'b1, 4'd15, 32'hCAFEBABE, 32'h0,        1'b0, 8'd4}, // R4
    '{1'b1, 1'b0, 4'd15, 32'h0,        32'hCAFEBABE, 1'b0, 8'd4}, // R4
    '{1'b1, 1'b0, 4'd4,  32'h0,        32'h12345678, 1'b0, 8'd4}, // R4 shared spare
    '{1'b0, 1'b0, 4'd15, 32'h0,        32'hCA55BABE, 1'b0, 8'd4}, // R4
    '{1'b1, 1'b0, 4'd10, 32'h0,        32'h0,        1'b1, 8'd6}, // R6 read spare
    '{1'b1, 1'b1, 4'd10, 32'hFFFFFFFF, 32'h0,        1'b1, 8'd6}, // R6 write spare
    '{1'b0, 1'b0, 4'd10, 32'h0,        32'hAAFEAA78, 1'b0, 8'd6}, // R6 ignored
    '{1'b1, 1'b0, 4'd2,  32'h0,        32'h0BADF00D, 1'b0, 8'd8}  // R8
  };

  task automatic check(input logic ok, input int rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] l, input logic [7:0] f,
                     input logic [3:0] s, input logic sc);
    cfg_we = 1'b1; cfg_line = l; cfg_fault = f; cfg_spare = s; cfg_sac = sc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic lp, input logic we, input logic [3:0] l,
                        input logic [31:0] wd);
    low_pwr = lp; req_valid = 1'b1; req_we = we; req_line = l; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held low in reset
    check(!rd_valid && !err && rd_data == 0, 1, {rd_valid, err, rd_data[29:0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rd_valid && !err, 1, {rd_valid, err}, 0);
    // R1 array cleared
    access(1'b0, 1'b0, 4'd7, 0);
    check(rd_valid && rd_data == 0, 1, rd_data, 0);
    // R2 no valid after idle
    @(negedge clk);
    check(!rd_valid, 2, rd_valid, 0);

    cfg(4'd4,  8'b0000_0011, 4'd10, 1'b0);
    cfg(4'd15, 8'b0011_0000, 4'd10, 1'b0);
    cfg(4'd10, 8'b0000_0000, 4'd10, 1'b1);
    cfg(4'd2,  8'b0000_0000, 4'd10, 1'b0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].lp, VEC[i].we, VEC[i].line, VEC[i].wd);
      check(err == VEC[i].eerr, VEC[i].req, err, VEC[i].eerr);
      if (VEC[i].we)
        check(!rd_valid, 2, rd_valid, 0); // R2 write gives no valid
      else
        check(rd_valid && rd_data == VEC[i].exp, VEC[i].req, rd_data, VEC[i].exp);
    end

    // R7 read with same-cycle cfg update of its own line uses old mask
    cfg_we = 1'b1; cfg_line = 4'd4; cfg_fault = 8'h00; cfg_spare = 4'd10; cfg_sac = 1'b0;
    access(1'b1, 1'b0, 4'd4, 0);
    cfg_we = 1'b0;
    check(rd_valid && rd_data == 32'h12345678, 7, rd_data, 32'h12345678);
    // R7 new mask in force next cycle
    access(1'b1, 1'b0, 4'd4, 0);
    check(rd_valid && rd_data == 32'h12345611, 7, rd_data, 32'h12345611);
    // R8 unfaulted low-power write stores whole line
    access(1'b1, 1'b1, 4'd4, 32'hDEADBEEF);
    access(1'b0, 1'b0, 4'd4, 0);
    check(rd_data == 32'hDEADBEEF, 8, rd_data, 32'hDEADBEEF);
    // R2 back-to-back reads each valid
    access(1'b0, 1'b0, 4'd2, 0);
    check(rd_valid && rd_data == 32'h0BADF00D, 2, rd_data, 32'h0BADF00D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule